// File: doc/BRIEF.md
# Watchdog Timer with Protected Control Writes

This block is a watchdog timer that sits on a small special-function-register bus of an 8-bit controller and counts core clock cycles. A two-bit select in a clock-control register picks one of four intervals, each eight times longer than the one before. When the running count reaches the selected interval, the block sets an interrupt flag. If resets are enabled, it then gives software a fixed grace period before it pulses a system reset output.

The watchdog control register holds the restart command, the reset-enable bit and the interrupt flag, and it is protected against stray writes. Software must write 0xAA and then 0x55 to a timed-access register. A write to the control register then takes effect only if it arrives within a short window after that sequence. Each unlock covers exactly one protected write. The clock-control register is not protected.

Top module: `wdt_core`

## Requirements
- R1: After reset, the clock-control register (address 0x8E) reads 0x03, the watchdog control register (address 0xD8) reads 0x00, and both wdog_irq and wdog_rst are low.
- R2: The clock-control register is written without any unlock. Bits 7:6 are the interval select, bits 2:0 are stored and read back, and bits 5:3 always read 0. Read data appears one clock after the address is presented.
- R3: Select value s gives an interval of 2^(BASE_LOG2 + 3*s) clocks, which is 2^17 for s=0 up to 2^26 for s=3 by default. wdog_irq (the flag, bit 3 of 0xD8) rises exactly that many clocks after a restart.
- R4: When reset-enable (bit 1 of 0xD8) is set at expiry, wdog_rst goes high exactly RST_DELAY clocks (default 512) after the interrupt, whether or not the flag was cleared. It stays high for one clock only.
- R5: When reset-enable is clear at expiry, wdog_rst stays low.
- R6: A write to 0xD8 that is not preceded by a valid unlock leaves the register unchanged.
- R7: The unlock is a write of 0xAA and then a write of 0x55 to address 0xC7. The protected write is accepted in any of the UNLOCK_WINDOW (default 3) clock cycles that follow the 0x55 write, and it is rejected after that.
- R8: Between the 0xAA write and the 0x55 write, any other bus write (to any address, or with any other value) cancels the sequence.
- R9: One unlock admits one protected write. A second write needs a new unlock.
- R10: Writing 1 to bit 0 of 0xD8 (restart, which reads 0) clears the counter and cancels a pending reset countdown.
- R11: A new interval select takes effect only at the next counter restart, either a restart command or the automatic wrap at expiry.
- R12: The flag is cleared by a protected write with bit 3 at 0. Bit 1 reads back the reset-enable setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_we | input | 1 | Write strobe, one write per cycle |
| sfr_rdata | output | 8 | Registered read data for the address of the previous cycle |
| wdog_irq | output | 1 | Interval-expired flag |
| wdog_rst | output | 1 | One-cycle system reset pulse |

## Verification
The hardest states to reach are the edges of the unlock window and a restart that lands while the reset countdown is already running. The bench unlocks and then waits a controlled number of idle cycles before the protected write, so the last accepted cycle and the first rejected cycle are each hit exactly. It also lets an interval expire with reset enabled and issues a restart partway through the grace period. With a reduced interval base and a short reset delay, the bench can sweep every select value with reset both enabled and disabled, and it counts the exact cycle of each event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] ADDR_CLKCTL  = 8'h8E;
  localparam logic [7:0] ADDR_WDCTL   = 8'hD8;
  localparam logic [7:0] ADDR_TA      = 8'hC7;
  localparam logic [7:0] KEY_FIRST    = 8'hAA;
  localparam logic [7:0] KEY_SECOND   = 8'h55;
  localparam logic [7:0] CLKCTL_RESET = 8'h03;

  localparam int WD_RESTART_BIT = 0;
  localparam int WD_RSTEN_BIT   = 1;
  localparam int WD_FLAG_BIT    = 3;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_ARMED = 2'd1,
    UL_OPEN  = 2'd2
  } unlock_state_e;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int UNLOCK_WINDOW = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       open_o
);
  localparam int WW = $clog2(UNLOCK_WINDOW + 1);

  unlock_state_e state_q;
  logic [WW-1:0] win_q;

  logic key1_wr, key2_wr, prot_wr;
  assign key1_wr = we && addr == ADDR_TA && wdata == KEY_FIRST;
  assign key2_wr = we && addr == ADDR_TA && wdata == KEY_SECOND;
  assign prot_wr = we && addr == ADDR_WDCTL;
  assign open_o  = state_q == UL_OPEN;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= UL_IDLE;
      win_q   <= '0;
    end else begin
      case (state_q)
        UL_IDLE: if (key1_wr) state_q <= UL_ARMED;
        UL_ARMED: begin
          if (key2_wr) begin
            state_q <= UL_OPEN;
            win_q   <= WW'(UNLOCK_WINDOW);
          end else if (key1_wr) begin
            state_q <= UL_ARMED;
          end else if (we) begin
            state_q <= UL_IDLE;
          end
        end
        UL_OPEN: begin
          if (prot_wr) begin
            state_q <= UL_IDLE;
          end else if (key1_wr) begin
            state_q <= UL_ARMED;
          end else if (win_q == WW'(1)) begin
            state_q <= UL_IDLE;
          end else begin
            win_q <= win_q - 1'b1;
          end
        end
        default: state_q <= UL_IDLE;
      endcase
    end
  end

  // R7: the open window never exceeds its configured length
  a_r7_window_bounded: assert property (@(posedge clk) disable iff (rst)
    open_o |-> (win_q != '0 && win_q <= WW'(UNLOCK_WINDOW)));

  // R8: the window can only open from the armed state
  a_r8_open_needs_armed: assert property (@(posedge clk) disable iff (rst)
    (state_q == UL_IDLE) |=> (state_q != UL_OPEN));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int BASE_LOG2 = 17,
  parameter int STEP_LOG2 = 3,
  parameter int RST_DELAY = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [1:0] sel_in,
  input  logic       rst_en,
  output logic       expire_o,
  output logic       wd_rst_o
);
  localparam int CW = BASE_LOG2 + 3 * STEP_LOG2;
  localparam int DW = $clog2(RST_DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic [1:0]    sel_q;
  logic          dly_on_q;
  logic [DW-1:0] dly_q;
  logic [CW:0]   limit;
  logic          cnt_last;

  always_comb begin
    limit = (CW + 1)'(1) << (BASE_LOG2 + STEP_LOG2 * int'(sel_q));
  end
  assign cnt_last = cnt_q == CW'(limit - 1'b1);
  assign expire_o = cnt_last && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      sel_q    <= '0;
      dly_on_q <= 1'b0;
      dly_q    <= '0;
      wd_rst_o <= 1'b0;
    end else begin
      wd_rst_o <= 1'b0;
      if (restart) begin
        cnt_q    <= '0;
        sel_q    <= sel_in;
        dly_on_q <= 1'b0;
        dly_q    <= '0;
      end else begin
        if (dly_on_q) begin
          if (dly_q == DW'(RST_DELAY - 1)) begin
            dly_on_q <= 1'b0;
            wd_rst_o <= 1'b1;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        if (cnt_last) begin
          cnt_q <= '0;
          sel_q <= sel_in;
          if (rst_en) begin
            dly_on_q <= 1'b1;
            dly_q    <= '0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R4: the reset pulse lasts one clock
  a_r4_rst_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wd_rst_o |=> !wd_rst_o);

  // R4: a reset pulse always comes out of a running countdown
  a_r4_rst_from_countdown: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst_o) |-> $past(dly_on_q));

  // R10: a restart leaves a cleared counter and no countdown
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0 && !dly_on_q && !wd_rst_o));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2     = 17,
  parameter int STEP_LOG2     = 3,
  parameter int RST_DELAY     = 512,
  parameter int UNLOCK_WINDOW = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_we,
  output logic [7:0] sfr_rdata,
  output logic       wdog_irq,
  output logic       wdog_rst
);
  logic [1:0] sel_q;
  logic [2:0] md_q;
  logic       rsten_q;
  logic       flag_q;
  logic       ta_open;
  logic       expire;
  logic       wr_clk, wr_wd_ok, restart;

  assign wr_clk   = sfr_we && sfr_addr == ADDR_CLKCTL;
  assign wr_wd_ok = sfr_we && sfr_addr == ADDR_WDCTL && ta_open;
  assign restart  = wr_wd_ok && sfr_wdata[WD_RESTART_BIT];

  wdt_unlock #(.UNLOCK_WINDOW(UNLOCK_WINDOW)) u_unlock (
    .clk   (clk),
    .rst   (rst),
    .we    (sfr_we),
    .addr  (sfr_addr),
    .wdata (sfr_wdata),
    .open_o(ta_open)
  );

  wdt_timer #(
    .BASE_LOG2(BASE_LOG2),
    .STEP_LOG2(STEP_LOG2),
    .RST_DELAY(RST_DELAY)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .sel_in  (sel_q),
    .rst_en  (rsten_q),
    .expire_o(expire),
    .wd_rst_o(wdog_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= CLKCTL_RESET[7:6];
      md_q      <= CLKCTL_RESET[2:0];
      rsten_q   <= 1'b0;
      flag_q    <= 1'b0;
      sfr_rdata <= '0;
    end else begin
      if (wr_clk) begin
        sel_q <= sfr_wdata[7:6];
        md_q  <= sfr_wdata[2:0];
      end
      if (wr_wd_ok) rsten_q <= sfr_wdata[WD_RSTEN_BIT];
      if (expire) flag_q <= 1'b1;
      else if (wr_wd_ok) flag_q <= sfr_wdata[WD_FLAG_BIT];
      case (sfr_addr)
        ADDR_CLKCTL: sfr_rdata <= {sel_q, 3'b000, md_q};
        ADDR_WDCTL:  sfr_rdata <= {4'b0000, flag_q, 1'b0, rsten_q, 1'b0};
        default:     sfr_rdata <= '0;
      endcase
    end
  end

  assign wdog_irq = flag_q;

  // R6: a write without an open unlock leaves reset-enable unchanged
  a_r6_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (sfr_we && sfr_addr == ADDR_WDCTL && !ta_open && !$past(rst)) |=> $stable(rsten_q));

  // R3: the flag rises only on expiry or on an accepted protected write
  a_r3_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_irq) |-> ($past(expire) || $past(wr_wd_ok)));

  // R2: unused clock-control bits read zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sfr_addr) == ADDR_CLKCTL) |-> (sfr_rdata[5:3] == 3'b000));
endmodule

// File: tb/test_wdt_core.sv
module test_wdt_core;
  localparam int BASE = 4;
  localparam int DLY  = 8;
  localparam int WIN  = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic       wdog_irq, wdog_rst;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  wdt_core #(.BASE_LOG2(BASE), .STEP_LOG2(3), .RST_DELAY(DLY), .UNLOCK_WINDOW(WIN)) i_wdt_core (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
    .sfr_rdata(sfr_rdata), .wdog_irq(wdog_irq), .wdog_rst(wdog_rst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic int interval(input int s);
    return 1 << (BASE + 3 * s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; sfr_we = 1'b0;
    @(negedge clk);
    d = sfr_rdata;
  endtask

  task automatic unlock();
    wr(8'hC7, 8'hAA);
    wr(8'hC7, 8'h55);
  endtask

  task automatic prot_wr(input logic [7:0] d);
    unlock();
    wr(8'hD8, d);
  endtask

  // counts cycles from now until irq is high; flags any reset seen first
  task automatic wait_irq(input int limit, output int k, output bit saw_rst);
    k = 0; saw_rst = 0;
    while (!wdog_irq && k < limit) begin
      @(negedge clk);
      k++;
      if (wdog_rst) saw_rst = 1;
    end
  endtask

  initial begin
    logic [7:0] d;
    int k, j;
    bit saw;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(wdog_irq == 0, "R1 irq", wdog_irq, 0);
    chk(wdog_rst == 0, "R1 rst", wdog_rst, 0);
    rd(8'h8E, d); chk(d == 8'h03, "R1 clkctl", d, 8'h03);
    rd(8'hD8, d); chk(d == 8'h00, "R1 wdctl", d, 8'h00);

    // R2 unprotected clock-control write, bits 5:3 read zero
    wr(8'h8E, 8'hFF);
    rd(8'h8E, d); chk(d == 8'hC7, "R2 readback", d, 8'hC7);
    wr(8'h8E, 8'h5A);
    rd(8'h8E, d); chk(d == 8'h42, "R2 readback2", d, 8'h42);

    // R3/R4/R5 sweep of select with reset enabled and disabled
    for (int s = 0; s < 4; s++) begin
      for (int en = 0; en < 2; en++) begin
        wr(8'h8E, {s[1:0], 6'h03});
        prot_wr(8'h01 | (en[0] ? 8'h02 : 8'h00));
        wait_irq(interval(s) + DLY + 20, k, saw);
        chk(k == interval(s), "R3 interval", k, interval(s));
        chk(!saw, "R4 no early rst", saw, 0);
        j = 0;
        while (!wdog_rst && j < DLY + 4) begin
          @(negedge clk); j++;
        end
        if (en == 1) begin
          chk(j == DLY, "R4 reset delay", j, DLY);
          @(negedge clk);
          chk(wdog_rst == 0, "R4 one cycle pulse", wdog_rst, 0);
        end else begin
          chk(j == DLY + 4, "R5 no reset", j, DLY + 4);
        end
      end
    end

    // R10 restart during pending countdown cancels reset
    wr(8'h8E, 8'h03);
    prot_wr(8'h03);
    wait_irq(100, k, saw);
    chk(k == interval(0), "R10 first expiry", k, interval(0));
    repeat (2) @(negedge clk);
    prot_wr(8'h03);
    wait_irq(100, k, saw);
    chk(!saw, "R10 countdown cancelled", saw, 0);
    chk(k == interval(0), "R10 counter cleared", k, interval(0));

    // R10 restart mid-count
    prot_wr(8'h01);
    repeat (7) @(negedge clk);
    prot_wr(8'h01);
    wait_irq(100, k, saw);
    chk(k == interval(0), "R10 mid-count restart", k, interval(0));

    // R11 select change waits for next restart
    prot_wr(8'h01);
    wr(8'h8E, 8'hC3);
    wait_irq(100, k, saw);
    chk(k + 1 == interval(0), "R11 old select kept", k + 1, interval(0));
    prot_wr(8'h01);
    wait_irq(interval(3) + 20, k, saw);
    chk(k == interval(3), "R11 new select used", k, interval(3));

    // R12 flag readback and clear
    rd(8'hD8, d); chk(d == 8'h08, "R12 flag read", d, 8'h08);
    prot_wr(8'h00);
    chk(wdog_irq == 0, "R12 flag cleared", wdog_irq, 0);
    rd(8'hD8, d); chk(d == 8'h00, "R12 cleared read", d, 8'h00);

    // R6 locked write ignored
    wr(8'hD8, 8'h02);
    rd(8'hD8, d); chk(d == 8'h00, "R6 locked write", d, 8'h00);

    // R7 last accepted cycle of the window
    unlock();
    repeat (WIN - 1) @(negedge clk);
    wr(8'hD8, 8'h02);
    rd(8'hD8, d); chk(d == 8'h02, "R7 last window cycle", d, 8'h02);
    // R7 first rejected cycle
    unlock();
    repeat (WIN) @(negedge clk);
    wr(8'hD8, 8'h00);
    rd(8'hD8, d); chk(d == 8'h02, "R7 window closed", d, 8'h02);
    // R7 immediate write
    prot_wr(8'h00);
    rd(8'hD8, d); chk(d == 8'h00, "R7 immediate", d, 8'h00);

    // R8 intervening write to another register
    wr(8'hC7, 8'hAA); wr(8'h8E, 8'h03); wr(8'hC7, 8'h55); wr(8'hD8, 8'h02);
    rd(8'hD8, d); chk(d == 8'h00, "R8 other address", d, 8'h00);
    // R8 wrong key value
    wr(8'hC7, 8'hAA); wr(8'hC7, 8'h12); wr(8'hC7, 8'h55); wr(8'hD8, 8'h02);
    rd(8'hD8, d); chk(d == 8'h00, "R8 wrong value", d, 8'h00);

    // R9 one write per unlock
    unlock();
    wr(8'hD8, 8'h02);
    wr(8'hD8, 8'h00);
    rd(8'hD8, d); chk(d == 8'h02, "R9 single use", d, 8'h02);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule